// File: doc/BRIEF.md
# Soft-Start Enable Sequencer

This block decides when a multi-phase buck regulator controller may run and then steps it through its digital start-up timeline. Time is counted in switching cycles: one pulse on `phase_tick` marks one cycle. Until the supply reset has completed, the enable comparator reports above-threshold and the 5-bit voltage identification code is something other than the reserved no-load code, the block stays off. In that state the PWM outputs float, the reference DAC is inhibited and power-good is low.

Once all three conditions hold, the sequence starts at the next clock edge. The PWM stage is first left floating while the reference stays held. Next the low-side switches are clamped by driving the PWM outputs low. Then PWM becomes active and a duty ramp index climbs from zero. Power-good is raised only when an 11-bit switching-cycle count reaches its terminal value. If any condition is lost, or the no-load code appears, the block falls back to off with the count cleared. Analog parts (comparators, error amplifier, sawtooth, DAC) are outside the block; only their digital control is produced here.

The controller has six states:
- `ST_OFF`: supply or enable missing.
- `ST_NOLOAD`: reserved code present.
- `ST_TRI`: start-up, outputs floating.
- `ST_CLAMP`: start-up, outputs forced low.
- `ST_RAMP`: start-up, duty ramping.
- `ST_GOOD`: start-up complete.

The transitions are:
- Any state goes to `ST_OFF` when supply or enable drops.
- Any state goes to `ST_NOLOAD` on the reserved code while supply and enable hold.
- `ST_OFF` and `ST_NOLOAD` go to `ST_TRI` as soon as all conditions hold.
- `ST_TRI` goes to `ST_CLAMP` on the tick that takes the count to 32.
- `ST_CLAMP` goes to `ST_RAMP` on the tick that takes it to 182.
- `ST_RAMP` goes to `ST_GOOD` on the tick that takes it to 2047.

Top module: `softstart_seq`

## Requirements
- R1: While `rst_n` is low, and after it is released, the outputs are in the off condition until the sequence starts: `pwm_mode` = 2'b00 (floating), `dac_inhibit` = 1, `ramp_en` = 0, `ramp_idx` = 0 and `pgood` = 0.
- R2: The sequence starts at the clock edge that samples `por_ok` = 1, `en_ok` = 1 and `vid_code` != 5'b11111 together. From that edge the switching-cycle count is 0. The start edge itself counts no tick.
- R3: The code 5'b11111 forces shutdown at the next edge from any state, giving the off condition of R1. Any other code, with supply and enable present, restarts the sequence from a count of 0.
- R4: If `por_ok` or `en_ok` is low at an edge, that edge returns the block to the off condition and clears the count, whatever the state was.
- R5: The count advances by one only on clocks where `phase_tick` = 1 and the sequence runs. It saturates at 2047. Ticks while off do not advance it.
- R6: For counts 0 to 31, `dac_inhibit` = 1, `pwm_mode` = 2'b00 and `ramp_en` = 0.
- R7: For counts 32 to 181, `pwm_mode` = 2'b01 (forced low), `dac_inhibit` = 0, `ramp_en` = 0 and `pgood` = 0.
- R8: From count 182 on, `pwm_mode` = 2'b10 (active) and `ramp_en` = 1. `ramp_idx` equals count minus 182, saturating at 255. The code 2'b11 never appears.
- R9: `pgood` rises exactly when the count reaches 2047, never earlier. It stays high while the enable conditions hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| por_ok | input | 1 | Supply power-on reset completed |
| en_ok | input | 1 | Digitized enable comparator above threshold |
| vid_code | input | 5 | Voltage identification code |
| phase_tick | input | 1 | One-clock pulse per switching cycle |
| dac_inhibit | output | 1 | Hold the reference DAC at zero |
| pwm_mode | output | 2 | 00 floating, 01 forced low, 10 active |
| ramp_en | output | 1 | Duty ramp running |
| ramp_idx | output | 8 | Duty ramp step, saturating |
| pgood | output | 1 | Power-good flag |

## Verification
The hardest situations to reach are the three phase boundaries. Each one falls on a single tick after thousands of clocks, and the end of the sequence needs 2047 ticks. To reach them, the stimulus runs complete start-ups with ticks on every clock and then on every third clock. An arithmetic model of the count is compared against the outputs on every clock, so each boundary tick is checked in the exact cycle it takes effect. Disruptive events are also placed deep inside specific phases: an enable drop mid-ramp, a reset-good drop mid-clamp, and the reserved code after power-good. A sweep over all 32 identification codes confirms that only the reserved one blocks the start.

// File: rtl/ssq_pkg.sv
package ssq_pkg;

    typedef enum logic [2:0] {
        ST_OFF    = 3'd0,
        ST_NOLOAD = 3'd1,
        ST_TRI    = 3'd2,
        ST_CLAMP  = 3'd3,
        ST_RAMP   = 3'd4,
        ST_GOOD   = 3'd5
    } seq_state_e;

    typedef enum logic [1:0] {
        PWM_FLOAT = 2'b00,
        PWM_LOW   = 2'b01,
        PWM_RUN   = 2'b10
    } pwm_mode_e;

endpackage

// File: rtl/ssq_qualify.sv
module ssq_qualify #(
    parameter int VID_W = 5
) (
    input  logic             por_ok,
    input  logic             en_ok,
    input  logic [VID_W-1:0] vid_code,
    output logic             supply_ok,
    output logic             noload
);

    localparam logic [VID_W-1:0] NOLOAD_CODE = '1;

    always_comb begin
        supply_ok = por_ok & en_ok;
        noload    = (vid_code == NOLOAD_CODE);
    end

endmodule

// File: rtl/ssq_sat_cnt.sv
module ssq_sat_cnt #(
    parameter int W = 11
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         adv,
    output logic [W-1:0] value,
    output logic         at_max
);

    localparam logic [W-1:0] TOP = '1;

    logic [W-1:0] value_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            value_q <= '0;
        end else if (clr) begin
            value_q <= '0;
        end else if (adv && (value_q != TOP)) begin
            value_q <= value_q + W'(1);
        end
    end

    always_comb begin
        value  = value_q;
        at_max = (value_q == TOP);
    end

endmodule

// File: rtl/ssq_fsm.sv
module ssq_fsm
    import ssq_pkg::*;
#(
    parameter int CNT_W   = 11,
    parameter int HIZ_CYC = 32,
    parameter int LOW_CYC = 150
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             supply_ok,
    input  logic             noload,
    input  logic             phase_tick,
    input  logic [CNT_W-1:0] cyc_cnt,
    output logic             cnt_clr,
    output logic             cnt_adv,
    output logic             ramp_clr,
    output logic             ramp_step,
    output logic             dac_inhibit,
    output pwm_mode_e        pwm_mode,
    output logic             ramp_en,
    output logic             pgood
);

    localparam int               CNT_MAX    = (1 << CNT_W) - 1;
    localparam logic [CNT_W-1:0] TRI_LAST   = CNT_W'(HIZ_CYC - 1);
    localparam logic [CNT_W-1:0] CLAMP_LAST = CNT_W'(HIZ_CYC + LOW_CYC - 1);
    localparam logic [CNT_W-1:0] GOOD_PREV  = CNT_W'(CNT_MAX - 1);

    seq_state_e state_q, state_d;
    logic       go;
    logic       running;
    logic       ramping;

    always_comb begin
        go      = supply_ok & ~noload;
        running = (state_q == ST_TRI) || (state_q == ST_CLAMP) ||
                  (state_q == ST_RAMP) || (state_q == ST_GOOD);
        ramping = (state_q == ST_RAMP) || (state_q == ST_GOOD);
    end

    always_comb begin
        state_d = state_q;
        if (!supply_ok) begin
            state_d = ST_OFF;
        end else if (noload) begin
            state_d = ST_NOLOAD;
        end else begin
            unique case (state_q)
                ST_OFF, ST_NOLOAD: state_d = ST_TRI;
                ST_TRI:   if (phase_tick && cyc_cnt == TRI_LAST)   state_d = ST_CLAMP;
                ST_CLAMP: if (phase_tick && cyc_cnt == CLAMP_LAST) state_d = ST_RAMP;
                ST_RAMP:  if (phase_tick && cyc_cnt == GOOD_PREV)  state_d = ST_GOOD;
                ST_GOOD:  state_d = ST_GOOD;
                default:  state_d = ST_OFF;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        cnt_clr     = ~go | ~running;
        cnt_adv     = go & running & phase_tick;
        ramp_clr    = ~go | ~ramping;
        ramp_step   = go & ramping & phase_tick;
        dac_inhibit = 1'b1;
        pwm_mode    = PWM_FLOAT;
        ramp_en     = 1'b0;
        pgood       = 1'b0;
        unique case (state_q)
            ST_OFF, ST_NOLOAD, ST_TRI: begin
                dac_inhibit = 1'b1;
                pwm_mode    = PWM_FLOAT;
            end
            ST_CLAMP: begin
                dac_inhibit = 1'b0;
                pwm_mode    = PWM_LOW;
            end
            ST_RAMP: begin
                dac_inhibit = 1'b0;
                pwm_mode    = PWM_RUN;
                ramp_en     = 1'b1;
            end
            ST_GOOD: begin
                dac_inhibit = 1'b0;
                pwm_mode    = PWM_RUN;
                ramp_en     = 1'b1;
                pgood       = 1'b1;
            end
            default: begin
                dac_inhibit = 1'b1;
                pwm_mode    = PWM_FLOAT;
            end
        endcase
    end

endmodule

// File: rtl/softstart_seq.sv
module softstart_seq
    import ssq_pkg::*;
#(
    parameter int VID_W   = 5,
    parameter int CNT_W   = 11,
    parameter int HIZ_CYC = 32,
    parameter int LOW_CYC = 150,
    parameter int RAMP_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              por_ok,
    input  logic              en_ok,
    input  logic [VID_W-1:0]  vid_code,
    input  logic              phase_tick,
    output logic              dac_inhibit,
    output logic [1:0]        pwm_mode,
    output logic              ramp_en,
    output logic [RAMP_W-1:0] ramp_idx,
    output logic              pgood
);

    logic             supply_ok;
    logic             noload;
    logic [CNT_W-1:0] cyc_cnt;
    logic             cnt_top;
    logic             ramp_top;
    logic             cnt_clr;
    logic             cnt_adv;
    logic             ramp_clr;
    logic             ramp_step;
    pwm_mode_e        mode_e;

    ssq_qualify #(.VID_W(VID_W)) u_qual (
        .por_ok    (por_ok),
        .en_ok     (en_ok),
        .vid_code  (vid_code),
        .supply_ok (supply_ok),
        .noload    (noload)
    );

    ssq_sat_cnt #(.W(CNT_W)) u_cyc_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (cnt_clr),
        .adv    (cnt_adv),
        .value  (cyc_cnt),
        .at_max (cnt_top)
    );

    ssq_sat_cnt #(.W(RAMP_W)) u_ramp_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (ramp_clr),
        .adv    (ramp_step),
        .value  (ramp_idx),
        .at_max (ramp_top)
    );

    ssq_fsm #(
        .CNT_W   (CNT_W),
        .HIZ_CYC (HIZ_CYC),
        .LOW_CYC (LOW_CYC)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .supply_ok   (supply_ok),
        .noload      (noload),
        .phase_tick  (phase_tick),
        .cyc_cnt     (cyc_cnt),
        .cnt_clr     (cnt_clr),
        .cnt_adv     (cnt_adv),
        .ramp_clr    (ramp_clr),
        .ramp_step   (ramp_step),
        .dac_inhibit (dac_inhibit),
        .pwm_mode    (mode_e),
        .ramp_en     (ramp_en),
        .pgood       (pgood)
    );

    always_comb begin
        pwm_mode = mode_e;
    end

    logic unused_flags;
    always_comb unused_flags = cnt_top ^ ramp_top;

endmodule

// File: rtl/softstart_seq_chk.sv
module softstart_seq_chk #(
    parameter int VID_W  = 5,
    parameter int RAMP_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              por_ok,
    input logic              en_ok,
    input logic [VID_W-1:0]  vid_code,
    input logic              phase_tick,
    input logic              dac_inhibit,
    input logic [1:0]        pwm_mode,
    input logic              ramp_en,
    input logic [RAMP_W-1:0] ramp_idx,
    input logic              pgood
);

    logic go;
    always_comb go = por_ok && en_ok && (vid_code != '1);

    a_r4_drop_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!por_ok || !en_ok) |=> (pwm_mode == 2'b00 && dac_inhibit && !ramp_en && !pgood && ramp_idx == '0));

    a_r3_noload_off: assert property (@(posedge clk) disable iff (!rst_n)
        (vid_code == '1) |=> (pwm_mode == 2'b00 && dac_inhibit && !pgood));

    a_r6_float_held: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm_mode == 2'b00) |-> (dac_inhibit && !ramp_en && !pgood));

    a_r7_clamp_outputs: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm_mode == 2'b01) |-> (!dac_inhibit && !ramp_en && !pgood));

    a_r5_clamp_waits_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (go && !phase_tick && pwm_mode == 2'b01) |=> (pwm_mode == 2'b01));

    a_r8_legal_mode: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm_mode != 2'b11) && ((pwm_mode == 2'b10) == ramp_en));

    a_r8_ramp_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (go && ramp_en && !phase_tick) |=> $stable(ramp_idx));

    a_r8_ramp_inc: assert property (@(posedge clk) disable iff (!rst_n)
        (go && ramp_en && phase_tick && ramp_idx != '1) |=> (ramp_idx == $past(ramp_idx) + 1'b1));

    a_r9_pgood_active: assert property (@(posedge clk) disable iff (!rst_n)
        pgood |-> (pwm_mode == 2'b10 && ramp_en && !dac_inhibit));

    a_r9_pgood_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (pgood && go) |=> pgood);

    a_r9_pgood_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pgood) |-> $past(phase_tick));

    a_r2_release_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dac_inhibit) |-> (pwm_mode == 2'b01 && $past(phase_tick)));

endmodule

bind softstart_seq softstart_seq_chk #(.VID_W(VID_W), .RAMP_W(RAMP_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .por_ok      (por_ok),
    .en_ok       (en_ok),
    .vid_code    (vid_code),
    .phase_tick  (phase_tick),
    .dac_inhibit (dac_inhibit),
    .pwm_mode    (pwm_mode),
    .ramp_en     (ramp_en),
    .ramp_idx    (ramp_idx),
    .pgood       (pgood)
);

// File: tb/softstart_seq_tb.sv
module softstart_seq_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       por_ok = 1'b0;
    logic       en_ok = 1'b0;
    logic [4:0] vid_code = 5'd0;
    logic       phase_tick = 1'b0;
    logic       dac_inhibit;
    logic [1:0] pwm_mode;
    logic       ramp_en;
    logic [7:0] ramp_idx;
    logic       pgood;

    int total = 0;
    int bad = 0;
    int n = 0;
    bit run = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    softstart_seq u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .por_ok      (por_ok),
        .en_ok       (en_ok),
        .vid_code    (vid_code),
        .phase_tick  (phase_tick),
        .dac_inhibit (dac_inhibit),
        .pwm_mode    (pwm_mode),
        .ramp_en     (ramp_en),
        .ramp_idx    (ramp_idx),
        .pgood       (pgood)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d (count=%0d)", req, act, exp, n);
        end
    endtask

    task automatic compare_all();
        string tag;
        int    e_mode;
        int    e_idx;
        bit    e_dac;
        bit    e_ren;
        bit    e_pg;
        if (!run) tag = (vid_code == 5'h1F) ? "R3" : "R4";
        else if (n < 32)  tag = "R6";
        else if (n < 182) tag = "R7";
        else              tag = "R8";
        e_mode = (!run || n < 32) ? 0 : (n < 182) ? 1 : 2;
        e_dac  = !run || n < 32;
        e_ren  = run && n >= 182;
        e_idx  = e_ren ? ((n - 182 > 255) ? 255 : n - 182) : 0;
        e_pg   = run && n == 2047;
        check({tag, " pwm_mode"}, pwm_mode, e_mode);
        check({tag, " dac_inhibit"}, dac_inhibit, e_dac);
        check({tag, " ramp_en"}, ramp_en, e_ren);
        check({tag, " ramp_idx"}, ramp_idx, e_idx);
        check("R9 pgood", pgood, e_pg);
    endtask

    // called at a falling edge: drive, clock, update model, compare
    task automatic step(input bit tk);
        bit go;
        phase_tick = tk;
        @(posedge clk);
        go = por_ok && en_ok && (vid_code != 5'h1F);
        if (!go) begin
            run = 0;
            n = 0;
        end else if (!run) begin
            run = 1;
            n = 0;
        end else if (tk && n < 2047) begin
            n++;
        end
        @(negedge clk);
        compare_all();
    endtask

    task automatic ticks(input int k, input int every);
        for (int i = 0; i < k; i++) begin
            for (int j = 1; j < every; j++) step(1'b0);
            step(1'b1);
        end
    endtask

    initial begin
        #1_000_000;
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=1 expected=0");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: off condition during and after reset
        check("R1 pwm_mode in reset", pwm_mode, 0);
        check("R1 dac_inhibit in reset", dac_inhibit, 1);
        check("R1 pgood in reset", pgood, 0);
        rst_n = 1'b1;
        step(1'b0);
        check("R1 ramp_idx after reset", ramp_idx, 0);
        check("R1 ramp_en after reset", ramp_en, 0);

        // R5: ticks while off are ignored
        ticks(20, 1);

        // R2: start and first boundary
        por_ok = 1; en_ok = 1; vid_code = 5'h0A;
        step(1'b0);
        check("R2 started still floating", pwm_mode, 0);
        ticks(31, 1);
        check("R6 floating through count 31", pwm_mode, 0);
        ticks(1, 1);
        check("R2 clamp at count 32", pwm_mode, 1);
        for (int i = 0; i < 10; i++) step(1'b0);
        check("R5 no advance without tick", pwm_mode, 1);
        ticks(149, 1);
        check("R7 clamp through count 181", pwm_mode, 1);
        ticks(1, 1);
        check("R8 active at 182", pwm_mode, 2);
        check("R8 ramp starts at 0", ramp_idx, 0);
        ticks(1864, 1);
        check("R9 pgood low at 2046", pgood, 0);
        ticks(1, 1);
        check("R9 pgood at 2047", pgood, 1);
        ticks(20, 1);
        check("R5 saturate keeps pgood", pgood, 1);

        // R3: reserved code from pgood, then restart
        vid_code = 5'h1F;
        step(1'b1);
        check("R3 shutdown on reserved code", pwm_mode, 0);
        ticks(5, 1);
        vid_code = 5'h03;
        step(1'b1);
        ticks(400, 2);
        check("R8 ramp after restart", ramp_idx, 400 - 182);

        // R4: enable drop mid ramp, supply drop mid clamp
        en_ok = 0;
        step(1'b1);
        check("R4 off after enable drop", ramp_en, 0);
        en_ok = 1;
        step(1'b0);
        ticks(100, 1);
        por_ok = 0;
        step(1'b0);
        check("R4 off after supply drop", pwm_mode, 0);
        por_ok = 1;
        step(1'b0);

        // R3/R2: sweep every identification code
        for (int v = 0; v < 32; v++) begin
            por_ok = 0;
            step(1'b0);
            vid_code = 5'(v);
            por_ok = 1;
            step(1'b0);
            ticks(40, 1);
            check(v == 31 ? "R3 sweep reserved" : "R2 sweep start", pwm_mode, v == 31 ? 0 : 1);
        end

        // R5/R9: full start with sparse ticks
        por_ok = 0;
        step(1'b0);
        vid_code = 5'h12;
        por_ok = 1;
        step(1'b1);
        while (n < 2046) ticks(1, 3);
        check("R9 pgood low before end sparse", pgood, 0);
        ticks(1, 3);
        check("R9 pgood at end sparse", pgood, 1);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule